// File: doc/BRIEF.md
# Full-Bridge Commutation Sequencer

This block is the synchronous control core of an H-bridge gate controller. It produces the four gate commands of the bridge: high-left, high-right, low-left and low-right. Its inputs are a supply-ready flag from an external undervoltage monitor, a bridge-off input, a start-release input, a divider-bypass strap, a clock-source select strap, an external drive level and an internal oscillator tick. Analog generation, comparators and gate drive strength are outside the block. All of these arrive as clean digital signals.

Three modes are ranked by priority. Off forces every gate low. Start parks both low sides on so that the bootstrap capacitors can charge. Run alternates between two diagonal positions. With the divider active, the bridge toggles on each falling edge of the selected source, so the bridge rate is half the source rate, and it always enters Run in position A. With the divider bypassed, the bridge position follows the external level, which keeps that signal's duty cycle.

Each change of the gate pattern comes with a one-cycle request strobe for a downstream dead-time stage.

Top module: `hb_commutator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the gates show the start pattern (low-left and low-right on, both high sides off) and reqStrobe is low. The gate bit order used throughout is {gateHiL, gateHiR, gateLoL, gateLoR}, so the start pattern is 4'b0011.
- R2: bridgeOff high overrides every other input. Two cycles after it is sampled high, all four gates are off (4'b0000).
- R3: With bridgeOff low and supplyOk low, the gates show the start pattern 4'b0011 two cycles later.
- R4: With bridgeOff low, supplyOk high and startRelease low, the gates stay at the start pattern 4'b0011.
- R5: In divided mode (divBypass low) during Run, each falling edge of the selected source swaps the bridge between position A (4'b1001) and position B (4'b0110). Rising edges have no effect.
- R6: In divided mode, every entry into Run shows position A first. This holds whether the bridge leaves Start or Off.
- R7: With divBypass high during Run, a high external level selects position A and a low level selects position B.
- R8: With extClkSel low, only oscTick falling edges advance the divided sequence and extDrive has no effect. With extClkSel high, only extDrive falling edges advance it and oscTick has no effect.
- R9: reqStrobe is high in exactly those cycles in which the gate pattern differs from that of the previous cycle.
- R10: A high side and the low side of the same leg are never commanded on together.
- R11: When supplyOk drops during Run, the gates return to the start pattern. When it returns, commutation resumes in position A in divided mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Undervoltage monitor reports supply ready |
| bridgeOff | input | 1 | Forces all gates off |
| startRelease | input | 1 | Low holds the start pattern after the supply is ready |
| divBypass | input | 1 | Strap: high makes the bridge follow the external level |
| extClkSel | input | 1 | Strap: high selects extDrive as the divided source, low selects oscTick |
| extDrive | input | 1 | External drive level, asynchronous |
| oscTick | input | 1 | Internal oscillator ramp-complete pulse, asynchronous |
| gateHiL | output | 1 | High-left gate command |
| gateHiR | output | 1 | High-right gate command |
| gateLoL | output | 1 | Low-left gate command |
| gateLoR | output | 1 | Low-right gate command |
| reqStrobe | output | 1 | One-cycle pulse marking a new gate pattern |

## Verification
Divided-mode commutation is driven by single oscTick pulses and then by square waves on extDrive, under each setting of the source select. This shows that only the selected source advances the bridge and that rising edges are ignored. Bypass mode is driven by slow and fast extDrive levels, which separates following the level from toggling on edges. Off, Start and supply-drop episodes are placed at both bridge positions. This shows that every re-entry into Run starts in position A and not in the position last held. Every cycle is compared against a behavioural reference timeline.

// File: rtl/hb_pkg.sv
package hb_pkg;

  localparam int GATE_W   = 4;
  localparam int IDX_HI_L = 3;
  localparam int IDX_HI_R = 2;
  localparam int IDX_LO_L = 1;
  localparam int IDX_LO_R = 0;

  typedef enum logic [1:0] {
    MODE_START = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_RUN   = 2'd2
  } bridgeMode_t;

  typedef struct packed {
    logic        follow;
    logic        followLvl;
    logic        park;
    logic        toggle;
    bridgeMode_t mode;
  } ctrlStrobe_t;

  function automatic logic [GATE_W-1:0] gatePattern(bridgeMode_t mode, logic posB);
    logic [GATE_W-1:0] g;
    g = '0;
    case (mode)
      MODE_START: begin
        g[IDX_LO_L] = 1'b1;
        g[IDX_LO_R] = 1'b1;
      end
      MODE_RUN: begin
        g[IDX_HI_L] = ~posB;
        g[IDX_LO_R] = ~posB;
        g[IDX_HI_R] = posB;
        g[IDX_LO_L] = posB;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        bridgeOff,
  input  logic        startRelease,
  input  logic        divBypass,
  input  logic        extClkSel,
  input  logic        extDrive,
  input  logic        oscTick,
  output ctrlStrobe_t strobe
);
  localparam int SRC_N = 2;
  localparam int SRC_OSC = 0;
  localparam int SRC_EXT = 1;

  logic [SRC_N-1:0] rawIn;
  logic [SRC_N-1:0] syncLvl;
  logic [SRC_N-1:0] prevLvl;
  logic [SRC_N-1:0] fallSeen;
  logic             srcFall;
  bridgeMode_t      modeQ;
  bridgeMode_t      modeNext;

  assign rawIn[SRC_OSC] = oscTick;
  assign rawIn[SRC_EXT] = extDrive;

  generate
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
      hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rstN   (rstN),
        .asyncIn(rawIn[s]),
        .syncOut(syncLvl[s])
      );
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevLvl[s] <= 1'b0;
        else       prevLvl[s] <= syncLvl[s];
      end
      assign fallSeen[s] = prevLvl[s] & ~syncLvl[s];
    end
  endgenerate

  assign srcFall = extClkSel ? fallSeen[SRC_EXT] : fallSeen[SRC_OSC];

  always_comb begin
    if (bridgeOff)                      modeNext = MODE_OFF;
    else if (!supplyOk || !startRelease) modeNext = MODE_START;
    else                                modeNext = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_START;
    else       modeQ <= modeNext;
  end

  always_comb begin
    strobe.mode      = modeQ;
    strobe.follow    = divBypass;
    strobe.followLvl = syncLvl[SRC_EXT];
    strobe.park      = !divBypass && (modeQ != MODE_RUN);
    strobe.toggle    = !divBypass && (modeQ == MODE_RUN) && srcFall;
  end
endmodule

// File: rtl/hb_dpath.sv
module hb_dpath
  import hb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic [GATE_W-1:0] gates,
  output logic              reqStrobe
);
  logic              posB;
  logic              posNext;
  logic [GATE_W-1:0] gatesNext;

  always_comb begin
    posNext = posB;
    if (strobe.follow)      posNext = ~strobe.followLvl;
    else if (strobe.park)   posNext = 1'b0;
    else if (strobe.toggle) posNext = ~posB;
  end

  assign gatesNext = gatePattern(strobe.mode, posB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posB      <= 1'b0;
      gates     <= gatePattern(MODE_START, 1'b0);
      reqStrobe <= 1'b0;
    end else begin
      posB      <= posNext;
      gates     <= gatesNext;
      reqStrobe <= (gatesNext != gates);
    end
  end
endmodule

// File: rtl/hb_commutator.sv
module hb_commutator
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic bridgeOff,
  input  logic startRelease,
  input  logic divBypass,
  input  logic extClkSel,
  input  logic extDrive,
  input  logic oscTick,
  output logic gateHiL,
  output logic gateHiR,
  output logic gateLoL,
  output logic gateLoR,
  output logic reqStrobe
);
  ctrlStrobe_t       strobe;
  logic [GATE_W-1:0] gates;

  hb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .supplyOk    (supplyOk),
    .bridgeOff   (bridgeOff),
    .startRelease(startRelease),
    .divBypass   (divBypass),
    .extClkSel   (extClkSel),
    .extDrive    (extDrive),
    .oscTick     (oscTick),
    .strobe      (strobe)
  );

  hb_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .gates    (gates),
    .reqStrobe(reqStrobe)
  );

  assign gateHiL = gates[IDX_HI_L];
  assign gateHiR = gates[IDX_HI_R];
  assign gateLoL = gates[IDX_LO_L];
  assign gateLoR = gates[IDX_LO_R];
endmodule

// File: rtl/hb_commutator_checker.sv
module hb_commutator_checker (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic bridgeOff,
  input logic startRelease,
  input logic gateHiL,
  input logic gateHiR,
  input logic gateLoL,
  input logic gateLoR,
  input logic reqStrobe
);
  logic [3:0] gv;
  assign gv = {gateHiL, gateHiR, gateLoL, gateLoR};

  // R10: no shoot-through on either leg
  a_r10_leg_safe: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHiL && gateLoL) && !(gateHiR && gateLoR));

  // R9: strobe marks exactly the cycles with a new pattern
  a_r9_req_marks_change: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (reqStrobe == (gv != $past(gv))));

  // R2: off overrides everything
  a_r2_off_all_low: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(bridgeOff, 2)) |-> (gv == 4'b0000));

  // R3: supply not ready parks low sides
  a_r3_supply_park: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && !$past(bridgeOff, 2) && !$past(supplyOk, 2)) |-> (gv == 4'b0011));

  // R4: held start keeps the start pattern
  a_r4_hold_start: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && !$past(bridgeOff, 2) && !$past(startRelease, 2)) |-> (gv == 4'b0011));
endmodule

bind hb_commutator hb_commutator_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .supplyOk    (supplyOk),
  .bridgeOff   (bridgeOff),
  .startRelease(startRelease),
  .gateHiL     (gateHiL),
  .gateHiR     (gateHiR),
  .gateLoL     (gateLoL),
  .gateLoR     (gateLoR),
  .reqStrobe   (reqStrobe)
);

// File: tb/hb_commutator_bench.sv
module hb_commutator_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0, bridgeOff = 1'b0, startRelease = 1'b0;
  logic divBypass = 1'b0, extClkSel = 1'b0, extDrive = 1'b0, oscTick = 1'b0;
  logic gateHiL, gateHiR, gateLoL, gateLoR, reqStrobe;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  hb_commutator u_hb_commutator (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .bridgeOff(bridgeOff),
    .startRelease(startRelease), .divBypass(divBypass), .extClkSel(extClkSel),
    .extDrive(extDrive), .oscTick(oscTick), .gateHiL(gateHiL), .gateHiR(gateHiR),
    .gateLoL(gateLoL), .gateLoR(gateLoR), .reqStrobe(reqStrobe)
  );

  // Reference timeline: input histories kept as queues (newest first)
  int extHist[$];
  int oscHist[$];
  int refMode = 0;  // 0 start, 1 off, 2 run
  int refPos = 0;   // 0 = A, 1 = B
  int refGates = 3;
  int refReq = 0;

  function automatic int patt(int mode, int pos);
    if (mode == 1) return 0;
    if (mode == 0) return 3;
    return (pos == 0) ? 9 : 6;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      extHist = '{0, 0, 0}; oscHist = '{0, 0, 0};
      refMode = 0; refPos = 0; refGates = 3; refReq = 0;
    end else begin
      int seenExt, seenOsc, newG, newPos, fall;
      seenExt = extHist[1]; seenOsc = oscHist[1];
      fall = extClkSel ? (extHist[2] == 1 && seenExt == 0) : (oscHist[2] == 1 && seenOsc == 0);
      newG = patt(refMode, refPos);
      refReq = (newG != refGates) ? 1 : 0;
      refGates = newG;
      newPos = refPos;
      if (divBypass) newPos = seenExt ? 0 : 1;
      else if (refMode != 2) newPos = 0;
      else if (fall != 0) newPos = 1 - refPos;
      refPos = newPos;
      refMode = bridgeOff ? 1 : ((!supplyOk || !startRelease) ? 0 : 2);
      extHist.push_front(int'(extDrive)); void'(extHist.pop_back());
      oscHist.push_front(int'(oscTick)); void'(oscHist.pop_back());
    end
  end

  // Per-cycle comparison against the reference timeline
  always @(negedge clk) begin
    if (rstN && !done) begin
      int act;
      act = {gateHiL, gateHiR, gateLoL, gateLoR};
      checks++;
      if (act != refGates) begin
        errors++;
        $display("FAIL %s gates actual %b expected %b at %0t", curReq, act[3:0], refGates[3:0], $time);
      end
      checks++;
      if (int'(reqStrobe) != refReq) begin
        errors++;
        $display("FAIL R9 reqStrobe actual %0d expected %0d at %0t", reqStrobe, refReq, $time);
      end
      checks++;
      if ((gateHiL && gateLoL) || (gateHiR && gateLoR)) begin
        errors++;
        $display("FAIL R10 leg conflict actual %b expected no conflict", act[3:0]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectGates(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {gateHiL, gateHiR, gateLoL, gateLoR};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s directed actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulseOsc();
    oscTick = 1'b1; cyc(2); oscTick = 1'b0; cyc(6);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 50000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected completion");
      finishRun();
    end
  end

  initial begin
    cyc(3);
    // R1: reset values
    expectGates("R1", 4'b0011);
    checks++;
    if (reqStrobe !== 1'b0) begin errors++; $display("FAIL R1 reqStrobe actual %b expected 0", reqStrobe); end
    rstN = 1'b1;
    cyc(1);
    expectGates("R1", 4'b0011);

    curReq = "R3"; cyc(5); expectGates("R3", 4'b0011);
    curReq = "R4"; supplyOk = 1'b1; cyc(5); expectGates("R4", 4'b0011);
    curReq = "R6"; startRelease = 1'b1; cyc(4); expectGates("R6", 4'b1001);

    curReq = "R5"; pulseOsc(); expectGates("R5", 4'b0110);
    pulseOsc(); expectGates("R5", 4'b1001);
    pulseOsc(); expectGates("R5", 4'b0110);

    curReq = "R8"; // ext ignored with oscillator selected
    for (int i = 0; i < 4; i++) begin extDrive = ~extDrive; cyc(5); end
    expectGates("R8", 4'b0110);

    curReq = "R2"; bridgeOff = 1'b1; cyc(3); expectGates("R2", 4'b0000);
    supplyOk = 1'b0; startRelease = 1'b0; cyc(3); expectGates("R2", 4'b0000);
    supplyOk = 1'b1; startRelease = 1'b1;
    curReq = "R6"; bridgeOff = 1'b0; cyc(3); expectGates("R6", 4'b1001);

    curReq = "R8"; extClkSel = 1'b1; cyc(2);
    pulseOsc(); expectGates("R8", 4'b1001);
    extDrive = 1'b1; cyc(6); expectGates("R8", 4'b1001);
    extDrive = 1'b0; cyc(6); expectGates("R8", 4'b0110);
    for (int i = 0; i < 12; i++) begin extDrive = ~extDrive; cyc(3); end

    curReq = "R11"; supplyOk = 1'b0; cyc(3); expectGates("R11", 4'b0011);
    supplyOk = 1'b1; cyc(3); expectGates("R11", 4'b1001);

    curReq = "R4"; startRelease = 1'b0; cyc(3); expectGates("R4", 4'b0011);
    startRelease = 1'b1; cyc(3);

    curReq = "R7"; divBypass = 1'b1;
    extDrive = 1'b1; cyc(6); expectGates("R7", 4'b1001);
    extDrive = 1'b0; cyc(6); expectGates("R7", 4'b0110);
    extDrive = 1'b1; cyc(6); expectGates("R7", 4'b1001);
    for (int i = 0; i < 20; i++) begin extDrive = ~extDrive; cyc(1 + (i % 3)); end
    extDrive = 1'b0; cyc(6); expectGates("R7", 4'b0110);
    pulseOsc(); expectGates("R7", 4'b0110);

    curReq = "R2"; bridgeOff = 1'b1; cyc(3); expectGates("R2", 4'b0000);
    bridgeOff = 1'b0; divBypass = 1'b0; extClkSel = 1'b0; cyc(3);
    curReq = "R6"; expectGates("R6", 4'b1001);
    curReq = "R5";
    for (int i = 0; i < 6; i++) begin oscTick = 1'b1; cyc(1); oscTick = 1'b0; cyc(4); end
    expectGates("R5", 4'b1001);
    cyc(4);
    finishRun();
  end
endmodule